// File: doc/BRIEF.md
# Burst Soft-Start Duty Sequencer

This block shapes the first moments of every dimming burst of a lamp driver channel. When the burst (dimming) signal rises, it issues a gate duty command for the next sixteen lamp cycles. The values come from eight programmable 3-bit step codes, packed as nibbles into a 32-bit profile word. Each code holds for two lamp cycles. The duty is given in ticks of a clock running at 512 times the lamp frequency.

One code value asks for the duty that was in force during the last lamp cycle of the previous burst. This lets a new burst resume near the level the regulator had settled on. Once the ramp is over, the block drops its soft-start flag and passes the regulator's own duty value through, so the downstream current loop takes over. While the burst signal is low, the duty command is zero.

The profile word is expected to come from configuration storage. Its power-up value is 32'h7765_4321, which gives a rising ramp that ends on the recalled duty.

Top module: `burst_ramp_seq`

## Requirements
- R1: While `burst_en` is low at a clock edge, `duty_out` is 0 and `ramp_active` is 0 after that edge. Both are 0 after reset.
- R2: A clock edge where `burst_en` is high and was low at the previous edge starts a ramp. After that edge, `ramp_active` is 1 and `duty_out` is the value for step 0.
- R3: The ramp ends on the sixteenth `lamp_tick` after the start edge, and `ramp_active` falls after that tick's edge. A tick that coincides with the start edge is not counted.
- R4: Ramp lamp cycles 2k+1 and 2k+2 (k = 0..7) use the nibble `profile[4k+3:4k]`. So the lowest byte supplies cycles 1 to 4, low nibble first.
- R5: A step changes only on a `lamp_tick`. Between ticks, `duty_out` holds its value.
- R6: Bit 3 of each nibble is ignored. Codes 0 to 6 give 0, 15, 30, 46, 66, 81 and 97 ticks (0, 3, 6, 9, 13, 16 and 19 percent of 512, rounded down).
- R7: Code 7 gives the duty recalled from the previous burst. This is 0 if no tick has been recorded since reset.
- R8: On each `lamp_tick` edge where `burst_en` was high at the previous edge, the current `duty_out` is recorded. This includes a tick on the same edge as the fall of `burst_en`. The value recorded last before a start edge is the one recalled in that burst.
- R9: Outside the ramp, with `burst_en` high, `duty_out` equals `reg_duty` as sampled at the previous edge.
- R10: If `burst_en` falls before the ramp ends, the ramp is abandoned. The next rise restarts it from step 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lamp_tick | input | 1 | One-clock pulse marking the end of a lamp cycle |
| burst_en | input | 1 | Dimming signal; high means the lamps are driven |
| profile | input | 32 | Eight 4-bit step codes, step 0 in bits 3:0 |
| reg_duty | input | 10 | Duty value from the current regulator, in ticks |
| duty_out | output | 10 | Gate duty command, in ticks of 512 per lamp cycle |
| ramp_active | output | 1 | High while the soft-start ramp is in control |

## Verification
Two pairs of events can land on the same clock edge. The first is a lamp tick arriving on the edge where the burst starts. The bench raises both together and then counts the ticks needed to end the ramp: the tick on the start edge must not be counted, so exactly sixteen further ticks are required. The second is the last lamp tick of a burst coinciding with the fall of the burst signal. There, the output must go to zero and the duty of that final cycle must still be recorded. The bench judges this by starting a new burst whose first step is code 7 and checking that it recalls 97 ticks.

// File: rtl/ss_pkg.sv
package ss_pkg;
    localparam int SS_TICKS   = 512;
    localparam int SS_STEPS   = 8;
    localparam int SS_HOLD    = 2;
    localparam int SS_CYCLES  = SS_STEPS * SS_HOLD;
    localparam int SS_CNT_W   = $clog2(SS_CYCLES);
    localparam int SS_DUTY_W  = $clog2(SS_TICKS) + 1;
    localparam int SS_PROF_W  = SS_STEPS * 4;
    localparam logic [SS_PROF_W-1:0] SS_PROF_RESET = 32'h7765_4321;

    typedef logic [SS_DUTY_W-1:0] duty_t;

    typedef struct packed {
        logic                burst;
        logic                active;
        logic [SS_CNT_W-1:0] cnt;
        duty_t               duty;
        duty_t               run_last;
        duty_t               prev;
    } seq_state_t;
endpackage

// File: rtl/ss_nibble_pick.sv
module ss_nibble_pick #(
    parameter int STEPS = 8,
    parameter int HOLD  = 2,
    parameter int CNT_W = 4
) (
    input  logic [STEPS*4-1:0] profile,
    input  logic [CNT_W-1:0]   cycle_idx,
    output logic [2:0]         code
);
    localparam int STEP_W = (STEPS > 1) ? $clog2(STEPS) : 1;

    logic [2:0]        codes [STEPS];
    logic [STEP_W-1:0] step;

    // bit 3 of every nibble is dropped here
    for (genvar g = 0; g < STEPS; g++) begin : g_nib
        assign codes[g] = profile[g*4 +: 3];
    end

    assign step = STEP_W'(cycle_idx / CNT_W'(HOLD));
    assign code = codes[step];
endmodule

// File: rtl/ss_duty_map.sv
module ss_duty_map #(
    parameter int TICKS  = 512,
    parameter int DUTY_W = 10
) (
    input  logic [2:0]        code,
    input  logic [DUTY_W-1:0] recall,
    output logic [DUTY_W-1:0] duty
);
    int pct;

    always_comb begin
        case (code)
            3'd1:    pct = 3;
            3'd2:    pct = 6;
            3'd3:    pct = 9;
            3'd4:    pct = 13;
            3'd5:    pct = 16;
            3'd6:    pct = 19;
            default: pct = 0;
        endcase
        if (code == 3'd7) duty = recall;
        else              duty = DUTY_W'((pct * TICKS) / 100);
    end
endmodule

// File: rtl/burst_ramp_seq.sv
module burst_ramp_seq
    import ss_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 lamp_tick,
    input  logic                 burst_en,
    input  logic [SS_PROF_W-1:0] profile,
    input  logic [SS_DUTY_W-1:0] reg_duty,
    output logic [SS_DUTY_W-1:0] duty_out,
    output logic                 ramp_active
);
    localparam logic [SS_CNT_W-1:0] LAST_CYC = SS_CNT_W'(SS_CYCLES - 1);

    seq_state_t          s_d, s_q;
    logic                rise;
    logic [SS_CNT_W-1:0] sel_cnt;
    logic [2:0]          step_code;
    duty_t               recall_sel;
    duty_t               step_duty;

    assign rise       = burst_en && !s_q.burst;
    assign sel_cnt    = rise ? '0 : s_q.cnt + 1'b1;
    assign recall_sel = rise ? s_q.run_last : s_q.prev;

    ss_nibble_pick #(
        .STEPS (SS_STEPS),
        .HOLD  (SS_HOLD),
        .CNT_W (SS_CNT_W)
    ) u_pick (
        .profile   (profile),
        .cycle_idx (sel_cnt),
        .code      (step_code)
    );

    ss_duty_map #(
        .TICKS  (SS_TICKS),
        .DUTY_W (SS_DUTY_W)
    ) u_map (
        .code   (step_code),
        .recall (recall_sel),
        .duty   (step_duty)
    );

    always_comb begin
        s_d       = s_q;
        s_d.burst = burst_en;
        // record the duty of each lamp cycle that ended inside a burst
        if (lamp_tick && s_q.burst) s_d.run_last = s_q.duty;

        if (!burst_en) begin
            s_d.active = 1'b0;
            s_d.cnt    = '0;
            s_d.duty   = '0;
        end else if (rise) begin
            s_d.active = 1'b1;
            s_d.cnt    = '0;
            s_d.prev   = s_q.run_last;
            s_d.duty   = step_duty;
        end else if (s_q.active) begin
            if (lamp_tick) begin
                if (s_q.cnt == LAST_CYC) begin
                    s_d.active = 1'b0;
                    s_d.duty   = reg_duty;
                end else begin
                    s_d.cnt  = s_q.cnt + 1'b1;
                    s_d.duty = step_duty;
                end
            end
        end else begin
            s_d.duty = reg_duty;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign duty_out    = s_q.duty;
    assign ramp_active = s_q.active;
endmodule

// File: rtl/ss_seq_chk.sv
module ss_seq_chk #(
    parameter int CYCLES = 16,
    parameter int DUTY_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lamp_tick,
    input logic              burst_en,
    input logic [DUTY_W-1:0] reg_duty,
    input logic [DUTY_W-1:0] duty_out,
    input logic              ramp_active
);
    localparam int CW = $clog2(CYCLES + 1);

    logic          b_prev;
    logic [CW-1:0] seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_prev <= 1'b0;
            seen   <= '0;
        end else begin
            b_prev <= burst_en;
            if (burst_en && !b_prev)                    seen <= '0;
            else if (ramp_active && lamp_tick && burst_en) seen <= seen + 1'b1;
        end
    end

    // R1
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !burst_en |=> (duty_out == '0 && !ramp_active));

    // R2
    ramp_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_en && !b_prev) |=> ramp_active);

    // R5
    step_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ramp_active && burst_en && !lamp_tick) |=> $stable(duty_out));

    // R9
    handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_en && b_prev && !ramp_active) |=> duty_out == $past(reg_duty));

    // R3
    ramp_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ramp_active |-> (seen < CW'(CYCLES)));
endmodule

bind burst_ramp_seq ss_seq_chk #(
    .CYCLES (ss_pkg::SS_CYCLES),
    .DUTY_W (ss_pkg::SS_DUTY_W)
) u_seq_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lamp_tick   (lamp_tick),
    .burst_en    (burst_en),
    .reg_duty    (reg_duty),
    .duty_out    (duty_out),
    .ramp_active (ramp_active)
);

// File: tb/test_burst_ramp_seq.sv
module test_burst_ramp_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lamp_tick = 1'b0;
    logic        burst_en = 1'b0;
    logic [31:0] profile = 32'h7765_4321;
    logic [9:0]  reg_duty = '0;
    logic [9:0]  duty_out;
    logic        ramp_active;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    burst_ramp_seq i_burst_ramp_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .lamp_tick   (lamp_tick),
        .burst_en    (burst_en),
        .profile     (profile),
        .reg_duty    (reg_duty),
        .duty_out    (duty_out),
        .ramp_active (ramp_active)
    );

    // profile, regulator duty, expected step duties (step 0 in low 10 bits)
    localparam logic [31:0] V_PROF [4] = '{32'h7765_4321, 32'h7765_4321, 32'hFEDC_BA98, 32'h0707_7000};
    localparam logic [9:0]  V_REG  [4] = '{10'd200, 10'd120, 10'd77, 10'd300};
    localparam logic [79:0] V_EXP  [4] = '{
        {10'd0,   10'd0,  10'd97, 10'd81, 10'd66, 10'd46, 10'd30, 10'd15},
        {10'd200, 10'd200,10'd97, 10'd81, 10'd66, 10'd46, 10'd30, 10'd15},
        {10'd120, 10'd97, 10'd81, 10'd66, 10'd46, 10'd30, 10'd15, 10'd0},
        {10'd0,   10'd77, 10'd0,  10'd77, 10'd77, 10'd0,  10'd0,  10'd0}
    };

    task automatic chk(input string req, input logic [9:0] act, input logic [9:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk) lamp_tick = 1'b1;
        @(negedge clk) lamp_tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic start();
        @(negedge clk) burst_en = 1'b1;
        @(negedge clk);
    endtask

    task automatic stop();
        @(negedge clk) burst_en = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset duty", duty_out, 10'd0);
        chk("R1 reset flag", 10'(ramp_active), 10'd0);
        rst_n = 1'b1;
        reg_duty = 10'd250;
        repeat (3) @(negedge clk);
        chk("R1 idle with reg_duty set", duty_out, 10'd0);

        for (int v = 0; v < 4; v++) begin
            profile  = V_PROF[v];
            reg_duty = V_REG[v];
            start();
            chk("R2 flag after rise", 10'(ramp_active), 10'd1);
            chk("R4 R6 R7 step 0", duty_out, V_EXP[v][9:0]);
            for (int c = 1; c < 16; c++) begin
                tick();
                chk((c % 2 == 1) ? "R5 second cycle of step" : "R4 R6 R7 new step",
                    duty_out, V_EXP[v][(c/2)*10 +: 10]);
                @(negedge clk);
                chk("R5 hold between ticks", duty_out, V_EXP[v][(c/2)*10 +: 10]);
            end
            tick();
            chk("R3 flag drops on 16th tick", 10'(ramp_active), 10'd0);
            chk("R9 regulator handoff", duty_out, V_REG[v]);
            tick(); tick(); tick();
            stop();
            chk("R1 zero after fall", duty_out, 10'd0);
        end

        // R10 truncated burst, R8 capture from it
        profile  = 32'h7765_4321;
        reg_duty = 10'd250;
        start();
        for (int c = 0; c < 5; c++) tick();
        chk("R10 mid-ramp duty", duty_out, 10'd46);
        stop();
        chk("R10 abandoned flag", 10'(ramp_active), 10'd0);
        chk("R10 abandoned duty", duty_out, 10'd0);
        start();
        chk("R10 restart from step 0", duty_out, 10'd15);
        for (int c = 1; c < 16; c++) begin
            tick();
            if (c >= 12) chk("R8 recall from short burst", duty_out, 10'd46);
        end
        tick();
        chk("R9 after restart ramp", duty_out, 10'd250);
        stop();

        // R3 tick on the start edge is not counted
        @(negedge clk) begin burst_en = 1'b1; lamp_tick = 1'b1; end
        @(negedge clk) lamp_tick = 1'b0;
        chk("R2 flag with coincident tick", 10'(ramp_active), 10'd1);
        chk("R3 coincident tick keeps step 0", duty_out, 10'd15);
        for (int c = 0; c < 15; c++) tick();
        chk("R3 still active after 15 ticks", 10'(ramp_active), 10'd1);
        tick();
        chk("R3 ends after 16 ticks", 10'(ramp_active), 10'd0);
        stop();

        // R8 last tick on the falling edge is recorded
        profile = 32'h6666_6666;
        start();
        for (int c = 0; c < 15; c++) tick();
        @(negedge clk) begin burst_en = 1'b0; lamp_tick = 1'b1; end
        @(negedge clk) lamp_tick = 1'b0;
        chk("R1 zero on fall with tick", duty_out, 10'd0);
        profile = 32'h0000_0007;
        repeat (2) @(negedge clk);
        start();
        chk("R8 R7 recall of tick at fall", duty_out, 10'd97);
        chk("R6 code 0 after recall", 10'(ramp_active), 10'd1);
        tick(); tick();
        chk("R6 code 0 step 1", duty_out, 10'd0);
        stop();

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule